// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block chooses the reply that endpoint 0 of a full-speed USB device gives to each decoded transaction during a control read transfer that firmware interprets. It receives one event per finished token/data exchange: the token kind, the parity of the data PID, a CRC-error flag and an empty-payload flag. It combines that event with three CPU control bits (FIFO enable, endpoint halt request, control-stall command) and with its own record of the transfer stage. One cycle later it presents the chosen handshake, a receive-FIFO write strobe, an interrupt pulse and a halt status bit.

The block tracks three stages: idle (no control transfer open), data (after an accepted SETUP) and status (after the first OUT of the transfer). A STALL given inside a control transfer is latched and repeated until the next accepted SETUP. A STALL forced by the control-stall command never shows up on the halt status.

Top module: `ctl_ep_responder`

## Requirements
- R1: An event with token SETUP (`tok_i`=2'b10), no CRC error and a DATA0 PID (`pid_data1_i`=0) gives `hs_o`=ACK (2'b00) with `hs_valid_o` and `irq_o` high one cycle later, whatever `fifo_en_i`, `halt_req_i` and `stall_cmd_i` are. It opens the data stage.
- R2: A SETUP event with a CRC error or a DATA1 PID gives no handshake and no interrupt. It changes neither the stage nor the latched STALL.
- R3: An IN event (`tok_i`=2'b01) returns STALL (2'b10) when the stall command or the halt request is set. Otherwise it returns NAK (2'b01) when `fifo_en_i` is low. Otherwise it returns ACK with `irq_o`.
- R4: Once STALL has been returned inside a control transfer, every later IN or OUT returns STALL until an accepted SETUP arrives. A corrupted SETUP does not clear this.
- R5: `halted_o` equals `halt_req_i` from the previous cycle and is not affected by `stall_cmd_i`.
- R6: In the status stage the halt request is ignored. The stall command gives STALL. Otherwise a low FIFO enable gives NAK. Otherwise the reply is ACK with `irq_o`, and the transfer returns to idle.
- R7: A status-stage OUT with a non-empty payload and a DATA1 PID is acknowledged, but `rxf_we_o` stays low.
- R8: A status-stage OUT that carries DATA0, with no STALL already due, returns STALL with `irq_o` high.
- R9: An IN or OUT event with a CRC error, or an event with the reserved token 2'b11, gives no handshake, no write and no interrupt.
- R10: An OUT (`tok_i`=2'b00) outside a control transfer follows the R3 priority. When it is ACKed it raises `irq_o`, and it raises `rxf_we_o` when the payload is not empty.
- R11: The first OUT after an accepted SETUP is treated as the status stage even if no IN came first. After that stage is ACKed, the next OUT is again treated as outside a control transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | One decoded transaction is presented this cycle |
| tok_i | input | 2 | Token: 00 OUT, 01 IN, 10 SETUP, 11 reserved |
| pid_data1_i | input | 1 | Data packet PID is DATA1 (0 = DATA0) |
| crc_err_i | input | 1 | Data packet was corrupted |
| empty_i | input | 1 | Data payload has zero length |
| fifo_en_i | input | 1 | CPU: endpoint FIFO ready |
| halt_req_i | input | 1 | CPU: endpoint halt request |
| stall_cmd_i | input | 1 | CPU: force STALL on the control transfer |
| hs_valid_o | output | 1 | A handshake is to be sent |
| hs_o | output | 2 | Handshake: 00 ACK, 01 NAK, 10 STALL |
| rxf_we_o | output | 1 | Write the OUT payload into the receive FIFO |
| irq_o | output | 1 | Interrupt pulse to the CPU |
| halted_o | output | 1 | Halt status seen by the CPU |

## Verification
The block has no parameters, so the bench builds its single configuration. In that configuration every stage, every token kind and all eight combinations of the control bits can be reached by directed sequences of only a few events. The scenarios therefore cover each stage transition, the latched STALL surviving a corrupted SETUP, and a status stage reached directly from SETUP.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {TOK_OUT = 2'b00, TOK_IN = 2'b01, TOK_SETUP = 2'b10, TOK_RSVD = 2'b11} tok_e;
  typedef enum logic [1:0] {HS_ACK = 2'b00, HS_NAK = 2'b01, HS_STALL = 2'b10} hs_e;
  typedef enum logic [1:0] {ST_IDLE = 2'b00, ST_DATA = 2'b01, ST_STATUS = 2'b10} stage_e;
endpackage

// File: rtl/ctl_ep_stage.sv
module ctl_ep_stage
  import ctl_ep_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   go_data_i,
  input  logic   go_status_i,
  input  logic   go_idle_i,
  input  logic   set_stall_i,
  output stage_e stage_o,
  output logic   sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_o  <= ST_IDLE;
      sticky_o <= 1'b0;
    end else if (go_data_i) begin
      stage_o  <= ST_DATA;
      sticky_o <= 1'b0;
    end else begin
      if (go_idle_i)        stage_o <= ST_IDLE;
      else if (go_status_i) stage_o <= ST_STATUS;
      if (go_idle_i)        sticky_o <= 1'b0;
      else if (set_stall_i) sticky_o <= 1'b1;
    end
  end
endmodule

// File: rtl/ctl_ep_decide.sv
module ctl_ep_decide
  import ctl_ep_pkg::*;
(
  input  logic   evt_i,
  input  tok_e   tok_i,
  input  logic   pid1_i,
  input  logic   crc_err_i,
  input  logic   empty_i,
  input  logic   fifo_en_i,
  input  logic   halt_i,
  input  logic   stall_cmd_i,
  input  stage_e stage_i,
  input  logic   sticky_i,
  output logic   hs_v_o,
  output hs_e    hs_o,
  output logic   we_o,
  output logic   irq_o,
  output logic   go_data_o,
  output logic   go_status_o,
  output logic   go_idle_o,
  output logic   set_stall_o
);
  logic in_ctl;
  assign in_ctl = (stage_i != ST_IDLE);

  always_comb begin
    hs_v_o = 1'b0; hs_o = HS_ACK; we_o = 1'b0; irq_o = 1'b0;
    go_data_o = 1'b0; go_status_o = 1'b0; go_idle_o = 1'b0; set_stall_o = 1'b0;
    if (evt_i) begin
      unique case (tok_i)
        TOK_SETUP: if (!crc_err_i && !pid1_i) begin
          hs_v_o = 1'b1; irq_o = 1'b1; go_data_o = 1'b1;
        end
        TOK_IN, TOK_OUT: if (!crc_err_i) begin
          hs_v_o = 1'b1;
          if (tok_i == TOK_OUT && in_ctl) begin
            // status stage: halt request not consulted
            go_status_o = 1'b1;
            if (sticky_i || stall_cmd_i) begin
              hs_o = HS_STALL; set_stall_o = 1'b1;
            end else if (!pid1_i) begin
              hs_o = HS_STALL; set_stall_o = 1'b1; irq_o = 1'b1;
            end else if (!fifo_en_i) begin
              hs_o = HS_NAK;
            end else begin
              irq_o = 1'b1; go_idle_o = 1'b1;
            end
          end else if ((in_ctl && sticky_i) || stall_cmd_i || halt_i) begin
            hs_o = HS_STALL; set_stall_o = in_ctl;
          end else if (!fifo_en_i) begin
            hs_o = HS_NAK;
          end else begin
            irq_o = 1'b1;
            we_o  = (tok_i == TOK_OUT) && !empty_i;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ctl_ep_responder.sv
module ctl_ep_responder
  import ctl_ep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_valid_i,
  input  logic [1:0] tok_i,
  input  logic       pid_data1_i,
  input  logic       crc_err_i,
  input  logic       empty_i,
  input  logic       fifo_en_i,
  input  logic       halt_req_i,
  input  logic       stall_cmd_i,
  output logic       hs_valid_o,
  output logic [1:0] hs_o,
  output logic       rxf_we_o,
  output logic       irq_o,
  output logic       halted_o
);
  stage_e stage_q;
  logic   sticky_q;
  logic   hs_v_d, we_d, irq_d, go_data, go_status, go_idle, set_stall;
  hs_e    hs_d;

  ctl_ep_decide i_decide (
    .evt_i(evt_valid_i), .tok_i(tok_e'(tok_i)), .pid1_i(pid_data1_i),
    .crc_err_i(crc_err_i), .empty_i(empty_i), .fifo_en_i(fifo_en_i),
    .halt_i(halt_req_i), .stall_cmd_i(stall_cmd_i), .stage_i(stage_q),
    .sticky_i(sticky_q), .hs_v_o(hs_v_d), .hs_o(hs_d), .we_o(we_d),
    .irq_o(irq_d), .go_data_o(go_data), .go_status_o(go_status),
    .go_idle_o(go_idle), .set_stall_o(set_stall)
  );

  ctl_ep_stage i_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_data_i(go_data),
    .go_status_i(go_status), .go_idle_i(go_idle), .set_stall_i(set_stall),
    .stage_o(stage_q), .sticky_o(sticky_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_valid_o <= 1'b0;
      hs_o       <= HS_ACK;
      rxf_we_o   <= 1'b0;
      irq_o      <= 1'b0;
      halted_o   <= 1'b0;
    end else begin
      hs_valid_o <= hs_v_d;
      hs_o       <= hs_d;
      rxf_we_o   <= we_d;
      irq_o      <= irq_d;
      halted_o   <= halt_req_i;
    end
  end
endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk
  import ctl_ep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_i,
  input logic [1:0] tok_i,
  input logic       pid_data1_i,
  input logic       crc_err_i,
  input logic       empty_i,
  input logic       stall_cmd_i,
  input logic       halt_req_i,
  input logic       hs_valid_o,
  input logic [1:0] hs_o,
  input logic       rxf_we_o,
  input logic       irq_o,
  input logic       halted_o,
  input stage_e     stage_q,
  input logic       sticky_q
);
  assert_setup_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && tok_i == 2'b10 && !crc_err_i && !pid_data1_i
    |=> hs_valid_o && hs_o == 2'b00 && irq_o);

  assert_bad_setup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && tok_i == 2'b10 && (crc_err_i || pid_data1_i)
    |=> !hs_valid_o && !irq_o && !rxf_we_o);

  assert_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && tok_i[1] == 1'b0 && !crc_err_i && sticky_q && stage_q != ST_IDLE
    |=> hs_valid_o && hs_o == 2'b10);

  assert_halt_view_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> halted_o == $past(halt_req_i));

  assert_status_data0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && tok_i == 2'b00 && stage_q != ST_IDLE && !sticky_q && !stall_cmd_i
      && !crc_err_i && !pid_data1_i
    |=> hs_o == 2'b10 && irq_o);

  assert_status_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && tok_i == 2'b00 && stage_q != ST_IDLE && !empty_i |=> !rxf_we_o);

  assert_corrupt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && (tok_i == 2'b11 || (tok_i[1] == 1'b0 && crc_err_i))
    |=> !hs_valid_o && !irq_o && !rxf_we_o);

  assert_write_only_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_we_o |-> hs_valid_o && hs_o == 2'b00 && irq_o);
endmodule

bind ctl_ep_responder ctl_ep_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .tok_i(tok_i),
  .pid_data1_i(pid_data1_i), .crc_err_i(crc_err_i), .empty_i(empty_i),
  .stall_cmd_i(stall_cmd_i), .halt_req_i(halt_req_i), .hs_valid_o(hs_valid_o),
  .hs_o(hs_o), .rxf_we_o(rxf_we_o), .irq_o(irq_o), .halted_o(halted_o),
  .stage_q(stage_q), .sticky_q(sticky_q)
);

// File: tb/test_ctl_ep_responder.sv
module test_ctl_ep_responder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0;
  logic [1:0] tok_i = 2'b00;
  logic       pid_data1_i = 1'b0, crc_err_i = 1'b0, empty_i = 1'b1;
  logic       fifo_en_i = 1'b0, halt_req_i = 1'b0, stall_cmd_i = 1'b0;
  logic       hs_valid_o, rxf_we_o, irq_o, halted_o;
  logic [1:0] hs_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [1:0] OUT = 2'b00, IN = 2'b01, SETUP = 2'b10, RSVD = 2'b11;
  localparam logic [1:0] ACK = 2'b00, NAK = 2'b01, STL = 2'b10;
  localparam logic [1:0] NONE = 2'b11;  // bench code: no handshake

  always #2.5 clk_i = ~clk_i;

  ctl_ep_responder i_ctl_ep_responder (.*);

  task automatic check(string req, logic [1:0] exp_hs, logic exp_irq, logic exp_we);
    logic [1:0] act;
    act = hs_valid_o ? hs_o : NONE;
    n_chk++;
    if (act !== exp_hs || irq_o !== exp_irq || rxf_we_o !== exp_we) begin
      n_fail++;
      $display("FAIL %s: hs/irq/we = %0d/%0d/%0d, expected %0d/%0d/%0d",
               req, act, irq_o, rxf_we_o, exp_hs, exp_irq, exp_we);
    end
  endtask

  // drive one event, sample the registered reply one cycle later
  task automatic xact(string req, logic [1:0] tok, logic p1, logic crc, logic emp,
                      logic [1:0] exp_hs, logic exp_irq, logic exp_we);
    @(negedge clk_i);
    evt_valid_i = 1'b1; tok_i = tok; pid_data1_i = p1; crc_err_i = crc; empty_i = emp;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    check(req, exp_hs, exp_irq, exp_we);
  endtask

  task automatic bits(logic f, logic h, logic s);
    @(negedge clk_i);
    fifo_en_i = f; halt_req_i = h; stall_cmd_i = s;
  endtask

  task automatic t_reset;
    check("R9 reset", NONE, 1'b0, 1'b0);
    n_chk++;
    if (halted_o !== 1'b0) begin n_fail++; $display("FAIL R5 reset halted %0d exp 0", halted_o); end
  endtask

  task automatic t_in_prio;
    bits(1, 1, 0); xact("R3 halt", IN, 1, 0, 0, STL, 0, 0);
    bits(1, 0, 1); xact("R3 cmd", IN, 1, 0, 0, STL, 0, 0);
    bits(0, 0, 0); xact("R3 nak", IN, 1, 0, 0, NAK, 0, 0);
    bits(1, 0, 0); xact("R3 ack", IN, 1, 0, 0, ACK, 1, 0);
  endtask

  task automatic t_out_idle;
    xact("R10 data", OUT, 0, 0, 0, ACK, 1, 1);
    xact("R10 empty", OUT, 1, 0, 1, ACK, 1, 0);
    bits(0, 0, 0); xact("R10 nak", OUT, 0, 0, 0, NAK, 0, 0);
    bits(1, 1, 0); xact("R10 halt", OUT, 0, 0, 0, STL, 0, 0);
    bits(1, 0, 0);
  endtask

  task automatic t_halted;
    bits(1, 1, 0); @(negedge clk_i);
    n_chk++; if (halted_o !== 1'b1) begin n_fail++; $display("FAIL R5 halted %0d exp 1", halted_o); end
    bits(1, 0, 1); @(negedge clk_i);
    n_chk++; if (halted_o !== 1'b0) begin n_fail++; $display("FAIL R5 cmd halted %0d exp 0", halted_o); end
    bits(1, 0, 0);
  endtask

  task automatic t_setup;
    bits(0, 1, 1); xact("R1 forced", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R2 crc", SETUP, 0, 1, 0, NONE, 0, 0);
    xact("R2 data1", SETUP, 1, 0, 0, NONE, 0, 0);
    bits(1, 0, 0);
  endtask

  task automatic t_status;
    xact("R1 open", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R3 data ack", IN, 1, 0, 0, ACK, 1, 0);
    bits(1, 1, 0);
    xact("R7 status", OUT, 1, 0, 0, ACK, 1, 0);
    bits(1, 0, 0);
    xact("R11 back idle", OUT, 0, 0, 0, ACK, 1, 1);
  endtask

  task automatic t_status_nak;
    xact("R1 open", SETUP, 0, 0, 0, ACK, 1, 0);
    bits(0, 0, 0); xact("R6 nak", OUT, 1, 0, 1, NAK, 0, 0);
    bits(1, 0, 0); xact("R6 ack", OUT, 1, 0, 1, ACK, 1, 0);
    xact("R11 idle after", OUT, 1, 0, 0, ACK, 1, 1);
    xact("R1 open", SETUP, 0, 0, 0, ACK, 1, 0);
    bits(1, 0, 1); xact("R6 cmd", OUT, 1, 0, 1, STL, 0, 0);
    bits(1, 0, 0);
  endtask

  task automatic t_sticky;
    xact("R1 open", SETUP, 0, 0, 0, ACK, 1, 0);
    bits(1, 0, 1); xact("R4 first", IN, 1, 0, 0, STL, 0, 0);
    bits(1, 0, 0); xact("R4 kept", IN, 1, 0, 0, STL, 0, 0);
    xact("R4 status", OUT, 1, 0, 1, STL, 0, 0);
    xact("R2 crc setup", SETUP, 0, 1, 0, NONE, 0, 0);
    xact("R4 after bad setup", IN, 1, 0, 0, STL, 0, 0);
    xact("R1 clear", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R4 cleared", IN, 1, 0, 0, ACK, 1, 0);
    xact("R6 close", OUT, 1, 0, 1, ACK, 1, 0);
  endtask

  task automatic t_data0;
    xact("R1 open", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R8 data0", OUT, 0, 0, 1, STL, 1, 0);
    xact("R4 after data0", OUT, 1, 0, 1, STL, 0, 0);
    xact("R1 clear", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R6 close", OUT, 1, 0, 1, ACK, 1, 0);
  endtask

  task automatic t_corrupt;
    xact("R9 in crc", IN, 1, 1, 0, NONE, 0, 0);
    xact("R9 out crc", OUT, 1, 1, 0, NONE, 0, 0);
    xact("R9 rsvd", RSVD, 0, 0, 0, NONE, 0, 0);
    xact("R1 open", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R9 crc in ctl", OUT, 0, 1, 0, NONE, 0, 0);
    xact("R8 still status", OUT, 0, 0, 0, STL, 1, 0);
    xact("R1 clear", SETUP, 0, 0, 0, ACK, 1, 0);
    xact("R6 close", OUT, 1, 0, 1, ACK, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_in_prio();
    t_out_idle();
    t_halted();
    t_setup();
    t_status();
    t_status_nak();
    t_sticky();
    t_data0();
    t_corrupt();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule